// File: doc/BRIEF.md
# Instruction Fetch Stage with Program Counter and Fetch/Decode Latch

This block is the first stage of a five-stage 32-bit pipelined processor. It keeps a program counter, reads a word from a 128-entry instruction store that holds fixed contents from power-up, and hands the fetched word to the decode stage through a pipeline latch. The latch also carries the address of the following instruction.

The store is indexed by words, so the counter advances by one per instruction. Only the seven low counter bits address the store. A 2:1 selector picks the next counter value. It takes either the incremented counter or a 32-bit jump target that arrives from a later stage, steered by a one-bit take-target input. The stage does not resolve branches, detect hazards or stall; it fetches on every clock edge.

Top module: `if_fetch_stage`

## Requirements
- R1: While `rst` is high at a rising edge, the counter, `ifid_instr` and `ifid_npc` become zero. The first edge after `rst` falls captures word 0 (`32'hA00000AA`) with `ifid_npc` = 1.
- R2: With `take_target` low, each rising edge captures into `ifid_instr` the store word at the current counter and into `ifid_npc` the counter plus one. The counter then advances by one.
- R3: Store word 0 holds `32'hA00000AA`. Word k for k = 1..9 holds k·`32'h10000011` (for example word 3 = `32'h30000033`). Words 10..127 hold zero. The contents never change.
- R4: The store is addressed by counter bits [6:0] only. A counter of 128+k fetches word k, while `ifid_npc` still shows the full 32-bit counter plus one.
- R5: When `take_target` is high at a rising edge, the counter loads `jump_target`. That edge still captures the word at the old counter. The next edge captures the word at the target with `ifid_npc` = target+1.
- R6: The increment is modulo 2^32: a counter of `32'hFFFFFFFF` yields `ifid_npc` = 0 and a next counter of 0.
- R7: While `take_target` is low, `jump_target` has no effect on the counter or the latch.
- R8: Reset takes priority over a requested jump: with `rst` and `take_target` both high, the counter becomes zero, not the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| take_target | input | 1 | 1 selects `jump_target` as the next counter, 0 selects counter+1 |
| jump_target | input | 32 | Next-counter value fed back from a later stage |
| ifid_instr | output | 32 | Latched fetched instruction |
| ifid_npc | output | 32 | Latched counter plus one |

## Verification
The hardest situations to reach from the ports are a counter above 127 and a counter at the top of the 32-bit range. Sequential fetch would need billions of cycles to reach them. The bench reaches them in one cycle by pulsing `take_target` with targets such as 131, 137 and `32'hFFFFFFFF`. It then checks the aliased store word and the wrapped `ifid_npc` on the edge after the jump. It also holds `take_target` low while changing `jump_target` every cycle, to show the target is ignored.

// File: rtl/if_pkg.sv
package if_pkg;
  localparam int unsigned XLEN = 32;

  // modular increment by one
  function automatic logic [XLEN-1:0] step_addr(input logic [XLEN-1:0] cur);
    return cur + {{(XLEN-1){1'b0}}, 1'b1};
  endfunction

  // fixed start-up contents of the instruction store
  function automatic logic [XLEN-1:0] boot_word(input int unsigned idx);
    logic [3:0] nib;
    if (idx > 9) return '0;
    nib = (idx == 0) ? 4'hA : 4'(idx);
    return {nib, 20'h00000, nib, nib};
  endfunction
endpackage

// File: rtl/if_step.sv
module if_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  assign nxt = cur + {{(W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/if_sel2.sv
module if_sel2 #(
  parameter int unsigned W = 32
) (
  input  logic         pick_a,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  assign y = pick_a ? a : b;
endmodule

// File: rtl/if_rom.sv
module if_rom #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 128
) (
  input  logic [W-1:0] pc,
  output logic [W-1:0] word
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] store [DEPTH];
  logic [AW-1:0] idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign store[i] = if_pkg::boot_word(i);
  end

  assign idx  = pc[AW-1:0];
  assign word = store[idx];
endmodule

// File: rtl/if_latch.sv
module if_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] instr_d,
  input  logic [W-1:0] npc_d,
  output logic [W-1:0] instr_q,
  output logic [W-1:0] npc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q <= '0;
      npc_q   <= '0;
    end else begin
      instr_q <= instr_d;
      npc_q   <= npc_d;
    end
  end
endmodule

// File: rtl/if_fetch_stage.sv
module if_fetch_stage #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_target,
  input  logic [W-1:0] jump_target,
  output logic [W-1:0] ifid_instr,
  output logic [W-1:0] ifid_npc
);
  logic [W-1:0] pc_q;
  logic [W-1:0] pc_plus;
  logic [W-1:0] pc_next;
  logic [W-1:0] fetched;
  logic         seen_rst;

  if_step #(.W(W)) u_step (.cur(pc_q), .nxt(pc_plus));

  if_sel2 #(.W(W)) u_sel (
    .pick_a(take_target), .a(jump_target), .b(pc_plus), .y(pc_next)
  );

  if_rom #(.W(W), .DEPTH(DEPTH)) u_rom (.pc(pc_q), .word(fetched));

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  if_latch #(.W(W)) u_latch (
    .clk(clk), .rst(rst),
    .instr_d(fetched), .npc_d(pc_plus),
    .instr_q(ifid_instr), .npc_q(ifid_npc)
  );

  // marks that at least one reset edge has happened, gates the checks
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    (seen_rst === 1'b1) && $past(rst) |-> (pc_q == '0 && ifid_instr == '0 && ifid_npc == '0)); // R1
  AST_NPC_FOLLOWS_PC: assert property (@(posedge clk) disable iff (rst)
    (seen_rst === 1'b1) && !$past(rst) |-> ifid_npc == $past(pc_q) + 1); // R2
  AST_JUMP_LOADS: assert property (@(posedge clk) disable iff (rst)
    (seen_rst === 1'b1) && !$past(rst) && $past(take_target) |-> pc_q == $past(jump_target)); // R5
  AST_TARGET_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (seen_rst === 1'b1) && !$past(rst) && !$past(take_target) |-> pc_q == $past(pc_q) + 1); // R7
  AST_RESET_WINS: assert property (@(posedge clk)
    (seen_rst === 1'b1) && $past(rst) && $past(take_target) |-> pc_q == '0); // R8
endmodule

// File: tb/sim_if_fetch_stage.sv
`timescale 1ns/100ps
module sim_if_fetch_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take_target = 1'b0;
  logic [31:0] jump_target = '0;
  logic [31:0] ifid_instr, ifid_npc;
  int n_run = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  if_fetch_stage u0 (.clk(clk), .rst(rst), .take_target(take_target),
    .jump_target(jump_target), .ifid_instr(ifid_instr), .ifid_npc(ifid_npc));

  function automatic logic [31:0] model_word(input logic [31:0] a);
    logic [6:0] k = a[6:0];
    if (k == 0) return 32'hA00000AA;
    if (k < 10) return 32'h10000011 * k;
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic jump_to(input logic [31:0] t);
    take_target = 1'b1; jump_target = t;
    tick();
    take_target = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick();
    chk("R1 instr", ifid_instr, 32'h0);
    chk("R1 npc", ifid_npc, 32'h0);
    rst = 1'b0; tick();
    chk("R1 first instr", ifid_instr, 32'hA00000AA);
    chk("R1 first npc", ifid_npc, 32'd1);
  endtask

  task automatic t_sequential();
    for (int k = 1; k < 14; k++) begin
      tick();
      chk("R2 npc", ifid_npc, k + 1);
      chk("R3 word", ifid_instr, model_word(k));
    end
  endtask

  task automatic t_branch();
    jump_to(32'd5);
    chk("R5 instr", ifid_instr, 32'h50000055);
    chk("R5 npc", ifid_npc, 32'd6);
    tick();
    chk("R5 after", ifid_npc, 32'd7);
  endtask

  task automatic t_alias();
    jump_to(32'd131);
    chk("R4 instr", ifid_instr, 32'h30000033);
    chk("R4 npc", ifid_npc, 32'd132);
    jump_to(32'd137);
    chk("R4 instr9", ifid_instr, 32'h90000099);
    jump_to(32'd127);
    chk("R3 last", ifid_instr, 32'h0);
  endtask

  task automatic t_wrap();
    jump_to(32'hFFFFFFFF);
    chk("R6 npc", ifid_npc, 32'h0);
    chk("R6 instr", ifid_instr, 32'h0);
    tick();
    chk("R6 next instr", ifid_instr, 32'hA00000AA);
    chk("R6 next npc", ifid_npc, 32'd1);
  endtask

  task automatic t_ignore();
    jump_to(32'd2);
    for (int k = 0; k < 4; k++) begin
      jump_target = 32'h40 + k;
      tick();
      chk("R7 npc", ifid_npc, 32'd4 + k);
      chk("R7 instr", ifid_instr, model_word(3 + k));
    end
  endtask

  task automatic t_reset_wins();
    rst = 1'b1; take_target = 1'b1; jump_target = 32'd8;
    tick();
    rst = 1'b0; take_target = 1'b0;
    tick();
    chk("R8 instr", ifid_instr, 32'hA00000AA);
    chk("R8 npc", ifid_npc, 32'd1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_sequential();
        t_branch();
        t_alias();
        t_wrap();
        t_ignore();
        t_reset_wins();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog got=1 exp=0");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule